// File: doc/BRIEF.md
# Calendar alarm match unit

This block watches a running BCD calendar and raises an alarm when the calendar reaches a programmed instant. There are seven alarm fields: seconds, minutes, hours, weekday, day of month, month and year. Each field can be turned on or off for comparison on its own, so an alarm can match on only some of the fields, for example "every hour at minute 42". The calendar counters are outside this block. Their current values arrive on input pins, and a one-second strobe tells the block when to evaluate a match.

The unit also has a periodic event generator. It divides a 256 Hz base strobe down to a selectable rate from 1/256 s to 2 s. One of its fixed taps, at 1/64 s, times the settling of alarm writes. Newly written alarm values are held in a shadow copy. They join the comparison only after two of these 1/64 s ticks. Software therefore waits out that interval, typically by polling the periodic flag at the 1/64 s rate.

Three sticky status flags record alarm, carry and periodic events. Each flag is gated by an enable bit of the same bit position to form an interrupt output, so one mask serves both registers. Register access is a plain single-cycle write strobe and a combinational read port. There is no data stream and no back-pressure: a write always lands on the clock edge where `wr_en` is high.

Top module: `calalm_unit`

## Requirements
- R1: After reset, every register reads 0x00 and the three interrupt outputs are low.
- R2: Addresses 2 to 7 hold the alarm fields in the order seconds, minutes, hours, weekday, day, month. In each of them bit 7 enables that field and the low bits hold the BCD value. Address 8 holds the year value, and bit 7 of address 9 enables the year. Each register reads back the last byte written, in the cycle after the write. The compare covers bits 6:0 for seconds, minutes and hours (bit 6 of hours included), bits 2:0 for weekday, bits 5:0 for day, bits 4:0 for month and bits 7:0 for year.
- R3: The comparison uses a live copy of the alarm registers. That copy takes the written values only on the second 1/64 s tick after the most recent alarm-register write. A 1/64 s tick is a base strobe on which the low two divider bits are 11. Another write in the meantime restarts the count.
- R4: The alarm flag (status bit 0) sets on a clock where `sec_tick` is high, at least one field is enabled, and every enabled field equals its calendar input. It then stays set when the match ends.
- R5: While no field is enabled in the live copy, the alarm flag never sets.
- R6: Status (address 0) holds bit 0 alarm, bit 1 carry and bit 2 periodic. Writing 0 to a bit clears it and writing 1 leaves it unchanged. A set event in the same cycle as a clear wins.
- R7: A high `carry_evt` sets the carry flag (status bit 1).
- R8: Control bits 7:4 hold a rate code c. For c from 6 to 15, the periodic flag (status bit 2) sets on each base strobe where the low c-6 bits of a 9-bit base-strobe counter are all ones. That gives 2^(c-6) strobes per event, and code 8 gives 1/64 s at a 256 Hz base. Codes 0 to 5 produce no events. The counter counts base strobes from reset.
- R9: Each interrupt output is its status bit ANDed with the control bit at the same position: bit 0 alarm, bit 1 carry, bit 2 periodic.
- R10: Control (address 1) reads back what was written with bit 3 forced to 0. Addresses 10 to 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | 256 Hz base strobe, one clock wide |
| sec_tick | input | 1 | One-second strobe that triggers alarm evaluation |
| carry_evt | input | 1 | Calendar carry event |
| cal_sec | input | 8 | Current seconds, BCD |
| cal_min | input | 8 | Current minutes, BCD |
| cal_hour | input | 8 | Current hours, BCD |
| cal_wday | input | 8 | Current weekday |
| cal_day | input | 8 | Current day of month, BCD |
| cal_mon | input | 8 | Current month, BCD |
| cal_year | input | 8 | Current year, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_carry | output | 1 | Carry interrupt |
| irq_period | output | 1 | Periodic interrupt |

## Verification
Two internal errors are hard to see at the ports until an alarm instant passes: a settle counter that runs early, and a live copy loaded at the wrong moment. Either one shows as `irq_alarm` rising on the first `sec_tick` after a single 1/64 s tick, or staying low after two. The bench therefore probes both sides of the settling edge, including a rewrite that restarts the count. A wrong divider phase shifts the periodic flag by whole base strobes. This is visible in the same cycle through status bit 2, and the per-clock reference model catches it at once. Mask or enable mix-ups are visible on the first evaluated second, by matching on a field whose ignored upper bits differ from the calendar.

// File: rtl/calalm_pkg.sv
package calalm_pkg;
  localparam int NUM_FIELDS = 7;   // sec, min, hour, wday, day, mon, year
  localparam int NUM_AREGS  = 8;   // six field regs, year value, year enable
  localparam int A_STAT     = 0;
  localparam int A_CTRL     = 1;
  localparam int A_FIRST    = 2;
  localparam int A_LAST     = A_FIRST + NUM_AREGS - 1;
  localparam int SETTLE_TICKS = 2;

  typedef struct packed {
    logic pf;
    logic cf;
    logic af;
  } flags_t;

  function automatic logic [7:0] field_mask(int f);
    case (f)
      0, 1, 2: return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/calalm_ticker.sv
module calalm_ticker #(
  parameter int DIV_W    = 9,
  parameter int CODE_MIN = 6,
  parameter int SETTLE_K = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic [3:0] rate,
  output logic       period_evt,
  output logic       tick64
);
  localparam logic [DIV_W-1:0] SMASK = DIV_W'((1 << SETTLE_K) - 1);

  logic [DIV_W-1:0] div_q;
  logic [3:0]       k;
  logic [DIV_W-1:0] pmask;
  logic             code_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         div_q <= '0;
    else if (base_tick) div_q <= div_q + 1'b1;
  end

  always_comb begin
    k       = rate - 4'(CODE_MIN);
    code_ok = (rate >= 4'(CODE_MIN)) && (int'(k) <= DIV_W);
    pmask   = (DIV_W'(1) << k) - DIV_W'(1);
  end

  assign period_evt = base_tick && code_ok && ((div_q & pmask) == pmask);
  assign tick64     = base_tick && ((div_q & SMASK) == SMASK);
endmodule

// File: rtl/calalm_match.sv
module calalm_match
  import calalm_pkg::*;
#(
  parameter int NFIELD = NUM_FIELDS,
  parameter int NREG   = NUM_AREGS,
  parameter int SETTLE = SETTLE_TICKS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(NREG)-1:0]       wr_idx,
  input  logic [7:0]                    wr_data,
  input  logic                          tick64,
  input  logic [NFIELD-1:0][7:0]        cal,
  output logic [NREG-1:0][7:0]          shadow_o,
  output logic [NFIELD-1:0]             act_en_o,
  output logic                          match_o
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [NREG-1:0][7:0] shadow_q, active_q;
  logic [CNT_W-1:0]     pend_q;
  logic [NFIELD-1:0]    hit;
  logic                 unused_yen_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      pend_q   <= '0;
    end else if (wr_en) begin
      shadow_q[wr_idx] <= wr_data;
      pend_q           <= CNT_W'(SETTLE);
    end else if (tick64 && pend_q != '0) begin
      pend_q <= pend_q - 1'b1;
      if (pend_q == CNT_W'(1)) active_q <= shadow_q;
    end
  end

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    localparam logic [7:0] FMASK = field_mask(f);
    if (f < NFIELD - 1) begin : g_own_en
      assign act_en_o[f] = active_q[f][7];
    end else begin : g_sep_en
      assign act_en_o[f] = active_q[NREG-1][7];
    end
    assign hit[f] = !act_en_o[f] || (((cal[f] ^ active_q[f]) & FMASK) == 8'h00);
  end

  assign unused_yen_low = ^active_q[NREG-1][6:0];
  assign match_o  = (|act_en_o) && (&hit);
  assign shadow_o = shadow_q;
endmodule

// File: rtl/calalm_unit.sv
module calalm_unit
  import calalm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DIV_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              sec_tick,
  input  logic              carry_evt,
  input  logic [7:0]        cal_sec,
  input  logic [7:0]        cal_min,
  input  logic [7:0]        cal_hour,
  input  logic [7:0]        cal_wday,
  input  logic [7:0]        cal_day,
  input  logic [7:0]        cal_mon,
  input  logic [7:0]        cal_year,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq_alarm,
  output logic              irq_carry,
  output logic              irq_period
);
  localparam int IDX_W = $clog2(NUM_AREGS);

  flags_t                     flags_q, keep;
  logic [7:0]                 ctrl_q;
  logic                       alarm_wr, stat_wr;
  logic [IDX_W-1:0]           wr_idx, rd_idx;
  logic                       period_evt, tick64, match;
  logic [NUM_AREGS-1:0][7:0]  shadow;
  logic [NUM_FIELDS-1:0]      act_en;
  logic [NUM_FIELDS-1:0][7:0] cal_bus;

  assign cal_bus  = {cal_year, cal_mon, cal_day, cal_wday, cal_hour, cal_min, cal_sec};
  assign alarm_wr = wr_en && (wr_addr >= ADDR_W'(A_FIRST)) && (wr_addr <= ADDR_W'(A_LAST));
  assign stat_wr  = wr_en && (wr_addr == ADDR_W'(A_STAT));
  assign wr_idx   = IDX_W'(wr_addr - ADDR_W'(A_FIRST));
  assign rd_idx   = IDX_W'(rd_addr - ADDR_W'(A_FIRST));

  calalm_ticker #(.DIV_W(DIV_W)) u_ticker (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rate(ctrl_q[7:4]),
    .period_evt(period_evt), .tick64(tick64)
  );

  calalm_match u_match (
    .clk(clk), .rst_n(rst_n), .wr_en(alarm_wr), .wr_idx(wr_idx),
    .wr_data(wr_data), .tick64(tick64), .cal(cal_bus),
    .shadow_o(shadow), .act_en_o(act_en), .match_o(match)
  );

  assign keep = stat_wr ? flags_t'(wr_data[2:0]) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ctrl_q  <= '0;
    end else begin
      flags_q.af <= (flags_q.af & keep.af) | (sec_tick & match);
      flags_q.cf <= (flags_q.cf & keep.cf) | carry_evt;
      flags_q.pf <= (flags_q.pf & keep.pf) | period_evt;
      if (wr_en && wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= wr_data & 8'hF7;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == ADDR_W'(A_STAT))      rd_data = {5'b0, flags_q};
    else if (rd_addr == ADDR_W'(A_CTRL)) rd_data = ctrl_q;
    else if (rd_addr >= ADDR_W'(A_FIRST) && rd_addr <= ADDR_W'(A_LAST))
      rd_data = shadow[rd_idx];
  end

  assign irq_alarm  = flags_q.af & ctrl_q[0];
  assign irq_carry  = flags_q.cf & ctrl_q[1];
  assign irq_period = flags_q.pf & ctrl_q[2];
endmodule

// File: rtl/calalm_chk.sv
module calalm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       carry_evt,
  input logic       tick64,
  input logic [2:0] flags,
  input logic [7:0] ctrl,
  input logic [6:0] act_en,
  input logic       irq_alarm,
  input logic       irq_period
);
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !(wr_en && wr_addr == 4'd0 && !wr_data[0]) |=> flags[0]); // R4
  AST_NO_ENABLE_NO_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[0] && act_en == 7'd0 |=> !flags[0]); // R5
  AST_SETTLE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick64 |=> $stable(act_en)); // R3
  AST_CARRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    carry_evt |=> flags[1]); // R7
  AST_CARRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 4'd0 && !wr_data[1] && !carry_evt |=> !flags[1]); // R6
  AST_ALARM_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> !irq_alarm); // R9
  AST_PERIOD_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] |-> !irq_period); // R9
endmodule

bind calalm_unit calalm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .carry_evt(carry_evt), .tick64(tick64), .flags(flags_q), .ctrl(ctrl_q),
  .act_en(act_en), .irq_alarm(irq_alarm), .irq_period(irq_period)
);

// File: tb/tb_calalm_unit.sv
module tb_calalm_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic base_tick = 0, sec_tick = 0, carry_evt = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [7:0] cal [7];
  logic irq_alarm, irq_carry, irq_period;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference model state
  int m_div, m_pend, m_af, m_cf, m_pf, m_ctrl;
  int m_sh [8];
  int m_ac [8];
  int msk [7] = '{127, 127, 127, 7, 63, 31, 255};

  always #(CLK_PERIOD/2) clk = ~clk;

  calalm_unit dut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .sec_tick(sec_tick),
    .carry_evt(carry_evt), .cal_sec(cal[0]), .cal_min(cal[1]), .cal_hour(cal[2]),
    .cal_wday(cal[3]), .cal_day(cal[4]), .cal_mon(cal[5]), .cal_year(cal[6]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_alarm(irq_alarm), .irq_carry(irq_carry), .irq_period(irq_period)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_pend = 0; m_af = 0; m_cf = 0; m_pf = 0; m_ctrl = 0;
      for (int i = 0; i < 8; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
    end else begin
      int code, t64, pev, anyen, allm, en, keep, a, d;
      a = int'(wr_addr); d = int'(wr_data);
      t64 = base_tick && (m_div % 4 == 3);
      code = m_ctrl >> 4;
      pev = base_tick && code >= 6 && ((m_div % (1 << (code - 6))) == ((1 << (code - 6)) - 1));
      anyen = 0; allm = 1;
      for (int f = 0; f < 7; f++) begin
        en = (f < 6) ? (m_ac[f] >> 7) & 1 : (m_ac[7] >> 7) & 1;
        if (en != 0) begin
          anyen = 1;
          if (((int'(cal[f]) ^ m_ac[f]) & msk[f]) != 0) allm = 0;
        end
      end
      keep = (wr_en && a == 0) ? d : 7;
      m_af = (m_af & keep & 1) | (sec_tick && anyen && allm ? 1 : 0);
      m_cf = (m_cf & (keep >> 1) & 1) | (carry_evt ? 1 : 0);
      m_pf = (m_pf & (keep >> 2) & 1) | (pev ? 1 : 0);
      if (wr_en && a >= 2 && a <= 9) begin
        m_sh[a-2] = d; m_pend = 2;
      end else if (t64 && m_pend > 0) begin
        if (m_pend == 1) for (int i = 0; i < 8; i++) m_ac[i] = m_sh[i];
        m_pend--;
      end
      if (wr_en && a == 1) m_ctrl = d & 'hF7;
      if (base_tick) m_div = (m_div + 1) % 512;
    end
  end

  function automatic int exp_rd(int a);
    if (a == 0) return m_af | (m_cf << 1) | (m_pf << 2);
    if (a == 1) return m_ctrl;
    if (a >= 2 && a <= 9) return m_sh[a-2];
    return 0;
  endfunction

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (int'(rd_data) != exp_rd(int'(rd_addr)) ||
          irq_alarm  !== 1'(m_af & m_ctrl & 1) ||
          irq_carry  !== 1'(m_cf & (m_ctrl >> 1) & 1) ||
          irq_period !== 1'(m_pf & (m_ctrl >> 2) & 1)) begin
        miscompares++;
        $display("FAIL R2/R4/R6/R8/R9 model compare t=%0t: rd[%0d]=%h irq=%b%b%b, expected %h irq=%b%b%b",
          $time, rd_addr, rd_data, irq_alarm, irq_carry, irq_period, exp_rd(int'(rd_addr)),
          1'(m_af & m_ctrl & 1), 1'(m_cf & (m_ctrl >> 1) & 1), 1'(m_pf & (m_ctrl >> 2) & 1));
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d); tick(); wr_en = 0;
  endtask
  task automatic rdchk(string tag, int a, int exp);
    rd_addr = 4'(a); @(negedge clk); #1; chk(tag, int'(rd_data), exp);
  endtask
  task automatic base(int n); base_tick = 1; repeat (n) tick(); base_tick = 0; endtask
  task automatic second(); sec_tick = 1; tick(); sec_tick = 0; endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int cnt;
    for (int f = 0; f < 7; f++) cal[f] = 0;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1: reset state
    for (int a = 0; a < 16; a++) rdchk("R1 reset read", a, 0);
    chk("R1 irqs", {irq_alarm, irq_carry, irq_period}, 0);
    // R10: control readback, bit 3 forced low, unused addresses
    wr(1, 'h8F); rdchk("R10 ctrl", 1, 'h87);
    rdchk("R10 unused addr", 12, 0);
    // R2/R3/R4: full alarm on sec/min/hour
    wr(2, 'hB0); wr(3, 'h95); wr(4, 'h89);
    rdchk("R2 readback sec", 2, 'hB0);
    cal[0] = 'h30; cal[1] = 'h15; cal[2] = 'h09;
    second(); chk("R3 not yet settled", irq_alarm, 0);
    base(8); second(); chk("R4 alarm fires", irq_alarm, 1);
    cal[0] = 'h31; second(); chk("R4 sticky", irq_alarm, 1);
    wr(0, 'hFE); chk("R6 write-0 clears alarm", irq_alarm, 0);
    rdchk("R6 status bit0", 0, m_cf << 1 | m_pf << 2);
    // R2: partial alarm, weekday upper bits ignored
    wr(2, 0); wr(4, 0); wr(3, 'hC2); wr(5, 'h8B);
    cal[1] = 'h42; cal[3] = 'h03; cal[0] = 'h59;
    base(8); second(); chk("R2 partial match with masked weekday", irq_alarm, 1);
    // R2: year enable lives in its own register
    wr(8, 'h26); wr(9, 'h80); wr(0, 'hFE); cal[6] = 'h25;
    base(8); second(); chk("R2 year mismatch", irq_alarm, 0);
    cal[6] = 'h26; second(); chk("R2 year match", irq_alarm, 1);
    // R3: rewrite restarts the settle count
    wr(0, 'hFE);
    for (int a = 2; a <= 9; a++) wr(a, 0);
    base(8);
    wr(2, 'h80); cal[0] = 0; base(4); wr(2, 'h80); base(4);
    second(); chk("R3 rewrite restarts settling", irq_alarm, 0);
    base(4); second(); chk("R3 settled after two ticks", irq_alarm, 1);
    // R5: nothing enabled
    wr(0, 'hFE);
    for (int a = 2; a <= 9; a++) wr(a, 0);
    for (int f = 0; f < 7; f++) cal[f] = 0;
    base(8); second(); second(); chk("R5 no field enabled", irq_alarm, 0);
    // R7/R9: carry flag and its enable
    wr(1, 'h85); wr(0, 0);
    carry_evt = 1; tick(); carry_evt = 0;
    rdchk("R7 carry flag", 0, 2 | m_pf << 2);
    chk("R9 carry masked", irq_carry, 0);
    wr(1, 'h87); chk("R9 carry enabled", irq_carry, 1);
    // R6: set beats clear in the same cycle
    carry_evt = 1; wr(0, 0); carry_evt = 0;
    chk("R6 set wins", irq_carry, 1);
    // R8: rate code 0 gives nothing, code 0xA every 16 strobes
    wr(1, 'h00); wr(0, 0); base(40);
    rdchk("R8 code 0 no periodic", 0, 0);
    wr(1, 'hA4); wr(0, 0);
    cnt = 0;
    base_tick = 1;
    for (int i = 0; i < 32; i++) begin
      if (irq_period) begin wr_en = 1; wr_addr = 0; wr_data = 0; end
      tick(); wr_en = 0;
      if (irq_period) cnt++;
    end
    base_tick = 0;
    chk("R8 two events in 32 strobes", cnt, 2);
    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      base_tick = ($urandom % 2) == 0;
      sec_tick  = ($urandom % 8) == 0;
      carry_evt = ($urandom % 16) == 0;
      wr_en     = ($urandom % 6) == 0;
      wr_addr   = 4'($urandom % 12);
      wr_data   = 8'($urandom);
      rd_addr   = 4'($urandom % 12);
      for (int f = 0; f < 7; f++) cal[f] = 8'($urandom % 2);
      tick();
    end
    {base_tick, sec_tick, carry_evt, wr_en} = '0;
    tick(); tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule